// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block guards the configuration space of a multi-function I/O controller. A host reaches it through two byte-wide I/O ports: an index port and a data port one address above it. While the block is locked, both ports act as if nothing is there. A fixed two-write key sequence on the index port opens configuration mode. In that mode the index port selects one of sixteen 8-bit configuration registers, and the data port reads or writes the selected register. A separate lock byte written to the index port closes the mode again.

A strap pin picks where the port pair sits. The block samples it only while reset is held, so a later change on the pin has no effect. Two of the sixteen registers are constant and report the device identifier and the silicon revision. A build parameter selects a sibling variant that opens on a different key byte. Reads are registered: the result appears one cycle after the request, qualified by a valid strobe.

Top module: `sio_cfg_unlock`

## Requirements
- R1: Two writes of the unlock key to the index port, with no other bus access between them, raise `cfg_mode` in the cycle after the second write. The key is 0x55 when `ALT_KEY` is 0.
- R2: Any bus read or write other than the second key write, made while the first key write is pending, cancels the pending sequence. A new pair of key writes is then needed.
- R3: In configuration mode, a write to the index port of any byte except 0xAA latches its low 4 bits as the register index. A read of the index port returns that index in bits 3:0, with bits 7:4 zero.
- R4: In configuration mode, a data port write stores the byte in the selected register, and a later data port read returns it. Example: register 0 holds 0x3F and register 1 holds 0x9F.
- R5: Writing 0xAA to the index port in configuration mode drops `cfg_mode` in the next cycle, and that write does not change the index.
- R6: While locked, data port writes change no register, and every read returns 0xFF. A read at an address outside the active port pair also returns 0xFF.
- R7: Register 13 reads as `DEV_ID` (default 0x65) and register 14 reads as `REV_ID` (default 0x01). Writes to these two registers are discarded.
- R8: If `strap_alt` is low during reset, the index and data ports are at 0x3F0 and 0x3F1. If it is high, they are at 0x370 and 0x371. Accesses to the other pair have no effect, and a change on `strap_alt` after reset does not move the ports.
- R9: Reset leaves the block locked, with the index at 0 and all writable registers at 0x00.
- R10: Every read request is answered exactly one cycle later, with `bus_rvalid` high for that one cycle.
- R11: With `ALT_KEY` set to 1, the unlock key is 0x66, and a pair of 0x55 writes does not open configuration mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the strap is sampled while it is low |
| strap_alt | input | 1 | Port location strap: low selects 0x3F0/0x3F1, high selects 0x370/0x371 |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | ADDR_W | I/O address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after bus_rd |
| cfg_mode | output | 1 | High while configuration mode is open |

## Verification
The assertions check on every cycle the properties that do not depend on history:
- configuration mode opens only from the armed state;
- the lock byte and any cancelling access close or drop the sequence;
- the index and the register array hold still unless a qualifying write arrives;
- locked reads return 0xFF;
- the identifier reads back as a constant;
- every read is answered one cycle later.

Only the bench scenarios can show the rest:
- that written values survive a lock and a later unlock;
- that the strap picks the port pair only at reset;
- that an interrupted key pair restarts from scratch;
- that the alternate-key variant ignores 0x55.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } lock_st_e;

    localparam logic [7:0] LOCK_BYTE = 8'hAA;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    function automatic logic [7:0] unlock_byte(input bit alt);
        return alt ? 8'h66 : 8'h55;
    endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] BASE_PRI = 16'h03F0,
    parameter logic [15:0] BASE_ALT = 16'h0370
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic [ADDR_W-1:0] addr,
    output logic              idx_hit,
    output logic              data_hit
);
    localparam logic [ADDR_W-1:0] PRI = ADDR_W'(BASE_PRI);
    localparam logic [ADDR_W-1:0] ALT = ADDR_W'(BASE_ALT);

    logic alt_d, alt_q;

    // strap captured only while reset is held
    always_comb begin
        alt_d = alt_q;
        if (!rst_n) alt_d = strap_alt;
    end

    always_ff @(posedge clk) begin
        alt_q <= alt_d;
    end

    logic [ADDR_W-1:0] base;
    always_comb begin
        base     = alt_q ? ALT : PRI;
        idx_hit  = (addr == base);
        data_hit = (addr == base + ADDR_W'(1));
    end

    a_r8_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(alt_q));

endmodule

// File: rtl/sio_unlock_seq.sv
module sio_unlock_seq
    import sio_cfg_pkg::*;
#(
    parameter bit ALT_KEY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rd,
    input  logic       idx_hit,
    input  logic [7:0] wdata,
    output logic       open
);
    localparam logic [7:0] KEY = unlock_byte(ALT_KEY);

    lock_st_e st_d, st_q;
    logic key_wr, lock_wr, any_acc;

    always_comb begin
        key_wr  = wr && idx_hit && (wdata == KEY);
        lock_wr = wr && idx_hit && (wdata == LOCK_BYTE);
        any_acc = wr || rd;
        st_d    = st_q;
        case (st_q)
            ST_LOCKED: if (key_wr) st_d = ST_ARMED;
            ST_ARMED: begin
                if (key_wr)       st_d = ST_OPEN;
                else if (any_acc) st_d = ST_LOCKED;
            end
            ST_OPEN:   if (lock_wr) st_d = ST_LOCKED;
            default:   st_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOCKED;
        else        st_q <= st_d;
    end

    assign open = (st_q == ST_OPEN);

    // R1: open only follows the armed state
    a_r1_open_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(st_q) == ST_ARMED);
    a_r2_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED && any_acc && !key_wr) |=> st_q == ST_LOCKED);
    a_r5_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (open && lock_wr) |=> !open);

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int         NREG    = 16,
    parameter logic [7:0] DEV_ID  = 8'h65,
    parameter logic [7:0] REV_ID  = 8'h01,
    parameter int         ID_IDX  = 13,
    parameter int         REV_IDX = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rd,
    input  logic       idx_hit,
    input  logic       data_hit,
    input  logic       open,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rvalid
);
    localparam int IDX_W = $clog2(NREG);
    localparam logic [IDX_W-1:0] ID_SEL  = IDX_W'(ID_IDX);
    localparam logic [IDX_W-1:0] REV_SEL = IDX_W'(REV_IDX);

    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic [IDX_W-1:0]     idx;
        logic [7:0]           rdata;
        logic                 rvalid;
    } cfg_st_t;

    cfg_st_t d, q;
    logic [7:0] sel_val;
    logic       ro_sel;

    always_comb begin
        ro_sel = (q.idx == ID_SEL) || (q.idx == REV_SEL);
        if (q.idx == ID_SEL)       sel_val = DEV_ID;
        else if (q.idx == REV_SEL) sel_val = REV_ID;
        else                       sel_val = q.regs[q.idx];

        d        = q;
        d.rvalid = rd;
        d.rdata  = IDLE_BYTE;
        if (rd && open && idx_hit)  d.rdata = {{(8-IDX_W){1'b0}}, q.idx};
        if (rd && open && data_hit) d.rdata = sel_val;

        if (wr && open && idx_hit && wdata != LOCK_BYTE)
            d.idx = wdata[IDX_W-1:0];
        if (wr && open && data_hit && !ro_sel)
            d.regs[q.idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;

    a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && open && idx_hit) |=> $stable(q.idx));
    a_r6_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && open && data_hit) |=> $stable(q.regs));
    a_r7_id_const: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && open && data_hit && q.idx == ID_SEL) |=> rdata == DEV_ID);
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock #(
    parameter int         ADDR_W  = 16,
    parameter bit         ALT_KEY = 1'b0,
    parameter int         NREG    = 16,
    parameter logic [7:0] DEV_ID  = 8'h65,
    parameter logic [7:0] REV_ID  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_alt,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    output logic              cfg_mode
);
    logic idx_hit, data_hit, open;

    sio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .addr(bus_addr),
        .idx_hit(idx_hit), .data_hit(data_hit)
    );

    sio_unlock_seq #(.ALT_KEY(ALT_KEY)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .idx_hit(idx_hit), .wdata(bus_wdata), .open(open)
    );

    sio_cfg_regs #(.NREG(NREG), .DEV_ID(DEV_ID), .REV_ID(REV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .idx_hit(idx_hit), .data_hit(data_hit), .open(open),
        .wdata(bus_wdata), .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    assign cfg_mode = open;

    a_r6_locked_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !open) |=> bus_rdata == 8'hFF);

endmodule

// File: tb/tb_sio_cfg_unlock.sv
module tb_sio_cfg_unlock;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata, rdata_v;
    logic        bus_rvalid, rvalid_v, cfg_mode, mode_v;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    sio_cfg_unlock dut (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cfg_mode(cfg_mode)
    );

    sio_cfg_unlock #(.ALT_KEY(1'b1)) dut_v (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_v),
        .bus_rvalid(rvalid_v), .cfg_mode(mode_v)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses arrive (R10)
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 8'h01, 8'h00);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic io_wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic io_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; strap_alt = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_NS * 20000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        check("R9 locked after reset", {7'd0, cfg_mode}, 8'h00);
        io_rd(16'h03F1, 8'hFF, "R6 locked data read");
        io_rd(16'h03F0, 8'hFF, "R6 locked index read");
        io_wr(16'h03F1, 8'h12);                       // R6: ignored
        io_wr(16'h03F0, 8'h55);
        io_wr(16'h03F0, 8'h55);
        check("R1 unlock", {7'd0, cfg_mode}, 8'h01);
        io_rd(16'h03F0, 8'h00, "R9 index zero");
        io_rd(16'h03F1, 8'h00, "R6 R9 reg0 untouched");
        io_wr(16'h03F0, 8'h00); io_wr(16'h03F1, 8'h3F);
        io_wr(16'h03F0, 8'h01); io_wr(16'h03F1, 8'h9F);
        io_wr(16'h03F0, 8'h00);
        io_rd(16'h03F1, 8'h3F, "R4 reg0");
        io_wr(16'h03F0, 8'h01);
        io_rd(16'h03F1, 8'h9F, "R4 reg1");
        io_wr(16'h03F0, 8'h1D);
        io_rd(16'h03F0, 8'h0D, "R3 index low bits");
        io_rd(16'h03F1, 8'h65, "R7 device id");
        io_wr(16'h03F1, 8'h00);
        io_rd(16'h03F1, 8'h65, "R7 id write discarded");
        io_wr(16'h03F0, 8'h0E);
        io_wr(16'h03F1, 8'h33);
        io_rd(16'h03F1, 8'h01, "R7 revision");
        io_wr(16'h03F0, 8'h0F); io_wr(16'h03F1, 8'hA5);
        io_rd(16'h03F1, 8'hA5, "R4 reg15");
        io_rd(16'h0371, 8'hFF, "R8 other pair read");
        io_wr(16'h03F0, 8'hAA);
        check("R5 lock", {7'd0, cfg_mode}, 8'h00);
        io_rd(16'h03F1, 8'hFF, "R6 read after lock");
        io_wr(16'h03F1, 8'h77);                       // R6: ignored
        io_wr(16'h03F0, 8'h55);
        io_rd(16'h03F1, 8'hFF, "R6 read while armed");
        io_wr(16'h03F0, 8'h55);
        check("R2 read cancels", {7'd0, cfg_mode}, 8'h00);
        io_wr(16'h03F0, 8'h12);
        io_wr(16'h03F0, 8'h55);
        check("R2 other write cancels", {7'd0, cfg_mode}, 8'h00);
        io_wr(16'h03F0, 8'h55);
        check("R1 unlock again", {7'd0, cfg_mode}, 8'h01);
        io_rd(16'h03F0, 8'h0F, "R5 lock byte left index");
        io_rd(16'h03F1, 8'hA5, "R6 locked write ignored");

        do_reset(1'b1);
        strap_alt = 1'b0;
        io_wr(16'h0370, 8'h55);
        io_wr(16'h0370, 8'h55);
        check("R8 alternate pair unlock", {7'd0, cfg_mode}, 8'h01);
        io_rd(16'h0371, 8'h00, "R9 reg0 cleared by reset");
        io_wr(16'h03F0, 8'hAA);
        check("R8 primary pair ignored", {7'd0, cfg_mode}, 8'h01);
        io_wr(16'h0370, 8'hAA);
        check("R5 lock on alternate pair", {7'd0, cfg_mode}, 8'h00);

        do_reset(1'b0);
        io_wr(16'h03F0, 8'h55);
        io_wr(16'h03F0, 8'h55);
        check("R11 variant ignores 0x55", {7'd0, mode_v}, 8'h00);
        io_wr(16'h03F0, 8'h66);
        io_wr(16'h03F0, 8'h66);
        check("R11 variant unlocks on 0x66", {7'd0, mode_v}, 8'h01);

        repeat (3) @(negedge clk);
        check("R10 all reads answered", 8'(exp_q.size()), 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule